// File: doc/BRIEF.md
# Timed Two-Axis Traffic Light Sequencer

This block drives the lamps of a four-way crossing. Opposite approaches always show the same colour, so it has two lamp groups: one for north-south and one for east-west. A four-phase state machine gives green to one axis at a time. Each phase lasts a fixed number of one-second ticks. The axis that has green steps from green to amber, and then the other axis gets green.

A single dwell counter counts the ticks of the `sec_tick` enable. In the last tick of the current phase's dwell it raises an expiry alarm. That alarm is the only thing that moves the machine to its next phase. The counter restarts from zero at every phase change.

The four dwell lengths are parameters. The defaults are 45 and 15 ticks for each axis, so each axis sees 60 ticks of red. The lamp outputs come straight from flops, so they never glitch.

Top module: `crossing_lights`

## Requirements
- R1: The synchronous active-high reset `rst` puts the crossing in the phase where north-south is green and east-west is red, and clears the dwell count. After reset this first phase therefore lasts the full NS_GO_TICKS ticks, even if reset arrives partway through a phase.
- R2: Each lamp group is a 3-bit one-hot code: bit 0 is green (3'b001), bit 1 is amber (3'b010) and bit 2 is red (3'b100). Exactly one bit of each group is set in every cycle after reset.
- R3: The two groups are never both non-red. In every cycle, bit 2 of `ns_lamp` or bit 2 of `ew_lamp` is set.
- R4: The phases repeat in this fixed order: NS green/EW red, NS amber/EW red, NS red/EW green, NS red/EW amber, then back to NS green/EW red.
- R5: Each phase lasts exactly its own number of ticks: NS_GO_TICKS, NS_AMBER_TICKS, EW_GO_TICKS and EW_AMBER_TICKS respectively. The outputs change in the cycle after the clock edge that samples the last tick of the phase.
- R6: A cycle with `sec_tick` low never changes the outputs, and a tick that is not the last of its phase does not change them either.
- R7: Each north-south red interval lasts exactly EW_GO_TICKS + EW_AMBER_TICKS ticks. With the defaults this is 60 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sec_tick | input | 1 | One-cycle pulse once per second; advances the dwell count |
| ns_lamp | output | 3 | North-south lamp group, one-hot {red, amber, green} |
| ew_lamp | output | 3 | East-west lamp group, one-hot {red, amber, green} |

## Verification
The hardest situations to reach from the ports are the exact expiry tick of each phase when ticks arrive sparsely and at irregular gaps, and a reset that lands partway through a later phase. With the default dwells, these take thousands of cycles to reach. The bench therefore builds the block with short, unequal dwells (3, 2, 4 and 1 ticks), so that every phase and its wrap are reached many times. It drives ticks at three densities: every cycle, every third cycle, and a pseudo-random pattern. It also inserts long tick-free gaps and a reset in the middle of a phase.

// File: rtl/xlight_pkg.sv
package xlight_pkg;

    typedef enum logic [1:0] {
        PH_NS_GO    = 2'd0,
        PH_NS_AMBER = 2'd1,
        PH_EW_GO    = 2'd2,
        PH_EW_AMBER = 2'd3
    } phase_t;

    typedef logic [2:0] lamp_t;

    localparam lamp_t LAMP_GO    = 3'b001;
    localparam lamp_t LAMP_AMBER = 3'b010;
    localparam lamp_t LAMP_STOP  = 3'b100;

    typedef struct packed {
        lamp_t ns;
        lamp_t ew;
    } lamp_pair_t;

    function automatic phase_t next_phase(input phase_t p);
        case (p)
            PH_NS_GO:    return PH_NS_AMBER;
            PH_NS_AMBER: return PH_EW_GO;
            PH_EW_GO:    return PH_EW_AMBER;
            default:     return PH_NS_GO;
        endcase
    endfunction

    function automatic lamp_pair_t lamps_of(input phase_t p);
        lamp_pair_t r;
        case (p)
            PH_NS_GO:    begin r.ns = LAMP_GO;    r.ew = LAMP_STOP;  end
            PH_NS_AMBER: begin r.ns = LAMP_AMBER; r.ew = LAMP_STOP;  end
            PH_EW_GO:    begin r.ns = LAMP_STOP;  r.ew = LAMP_GO;    end
            default:     begin r.ns = LAMP_STOP;  r.ew = LAMP_AMBER; end
        endcase
        return r;
    endfunction

    function automatic int pick_dwell(input phase_t p, input int d0, input int d1,
                                      input int d2, input int d3);
        case (p)
            PH_NS_GO:    return d0;
            PH_NS_AMBER: return d1;
            PH_EW_GO:    return d2;
            default:     return d3;
        endcase
    endfunction

endpackage

// File: rtl/xlight_dwell_timer.sv
module xlight_dwell_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [CW-1:0] last_count,
    output logic          alarm
);
    logic [CW-1:0] cnt_q;

    assign alarm = tick && (cnt_q == last_count);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (alarm) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/xlight_phase_reg.sv
module xlight_phase_reg
    import xlight_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   advance,
    output phase_t phase_q,
    output phase_t phase_d
);
    always_comb begin
        phase_d = advance ? next_phase(phase_q) : phase_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_NS_GO;
        end else begin
            phase_q <= phase_d;
        end
    end
endmodule

// File: rtl/xlight_lamp_reg.sv
module xlight_lamp_reg
    import xlight_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_t phase_d,
    output lamp_t  ns_lamp,
    output lamp_t  ew_lamp
);
    lamp_pair_t lamps_q;
    lamp_pair_t lamps_d;

    always_comb begin
        lamps_d = lamps_of(phase_d);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lamps_q <= lamps_of(PH_NS_GO);
        end else begin
            lamps_q <= lamps_d;
        end
    end

    assign ns_lamp = lamps_q.ns;
    assign ew_lamp = lamps_q.ew;
endmodule

// File: rtl/crossing_lights.sv
module crossing_lights #(
    parameter int NS_GO_TICKS    = 45,
    parameter int NS_AMBER_TICKS = 15,
    parameter int EW_GO_TICKS    = 45,
    parameter int EW_AMBER_TICKS = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sec_tick,
    output logic [2:0] ns_lamp,
    output logic [2:0] ew_lamp
);
    import xlight_pkg::*;

    localparam int MAX_A     = (NS_GO_TICKS > NS_AMBER_TICKS) ? NS_GO_TICKS : NS_AMBER_TICKS;
    localparam int MAX_B     = (EW_GO_TICKS > EW_AMBER_TICKS) ? EW_GO_TICKS : EW_AMBER_TICKS;
    localparam int MAX_DWELL = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW        = (MAX_DWELL > 1) ? $clog2(MAX_DWELL) : 1;

    phase_t        phase_q;
    phase_t        phase_d;
    logic          alarm;
    logic [CW-1:0] last_count;

    always_comb begin
        last_count = CW'(pick_dwell(phase_q, NS_GO_TICKS, NS_AMBER_TICKS,
                                    EW_GO_TICKS, EW_AMBER_TICKS) - 1);
    end

    xlight_dwell_timer #(.CW(CW)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .tick       (sec_tick),
        .last_count (last_count),
        .alarm      (alarm)
    );

    xlight_phase_reg u_phase (
        .clk     (clk),
        .rst     (rst),
        .advance (alarm),
        .phase_q (phase_q),
        .phase_d (phase_d)
    );

    xlight_lamp_reg u_lamps (
        .clk     (clk),
        .rst     (rst),
        .phase_d (phase_d),
        .ns_lamp (ns_lamp),
        .ew_lamp (ew_lamp)
    );
endmodule

// File: rtl/xlight_checker.sv
module xlight_checker #(
    parameter int NS_GO_TICKS    = 45,
    parameter int NS_AMBER_TICKS = 15,
    parameter int EW_GO_TICKS    = 45,
    parameter int EW_AMBER_TICKS = 15
) (
    input logic       clk,
    input logic       rst,
    input logic       sec_tick,
    input logic [2:0] ns_lamp,
    input logic [2:0] ew_lamp
);
    // Phase as seen at the outputs, and ticks seen in it so far
    int   seen_q;
    int   dw;
    logic last_tick;

    always_comb begin
        if (ns_lamp == 3'b001)      dw = NS_GO_TICKS;
        else if (ns_lamp == 3'b010) dw = NS_AMBER_TICKS;
        else if (ew_lamp == 3'b001) dw = EW_GO_TICKS;
        else                        dw = EW_AMBER_TICKS;
        last_tick = sec_tick && (seen_q == dw - 1);
    end

    always_ff @(posedge clk) begin
        if (rst)            seen_q <= 0;
        else if (last_tick) seen_q <= 0;
        else if (sec_tick)  seen_q <= seen_q + 1;
    end

    // R2
    a_r2_ns_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(ns_lamp) == 1);
    a_r2_ew_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(ew_lamp) == 1);
    // R3
    a_r3_one_red: assert property (@(posedge clk) disable iff (rst)
        ns_lamp[2] || ew_lamp[2]);
    // R4
    a_r4_ns_go_next: assert property (@(posedge clk) disable iff (rst)
        (ns_lamp == 3'b001) |=> (ns_lamp == 3'b001 || ns_lamp == 3'b010));
    a_r4_ns_amber_next: assert property (@(posedge clk) disable iff (rst)
        (ns_lamp == 3'b010) |=> (ns_lamp == 3'b010 || ew_lamp == 3'b001));
    a_r4_ew_go_next: assert property (@(posedge clk) disable iff (rst)
        (ew_lamp == 3'b001) |=> (ew_lamp == 3'b001 || ew_lamp == 3'b010));
    a_r4_ew_amber_next: assert property (@(posedge clk) disable iff (rst)
        (ew_lamp == 3'b010) |=> (ew_lamp == 3'b010 || ns_lamp == 3'b001));
    // R5
    a_r5_expiry_moves: assert property (@(posedge clk) disable iff (rst)
        last_tick |=> ({ns_lamp, ew_lamp} != $past({ns_lamp, ew_lamp})));
    // R6
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !last_tick |=> $stable({ns_lamp, ew_lamp}));
endmodule

bind crossing_lights xlight_checker #(
    .NS_GO_TICKS    (NS_GO_TICKS),
    .NS_AMBER_TICKS (NS_AMBER_TICKS),
    .EW_GO_TICKS    (EW_GO_TICKS),
    .EW_AMBER_TICKS (EW_AMBER_TICKS)
) u_xlight_checker (
    .clk      (clk),
    .rst      (rst),
    .sec_tick (sec_tick),
    .ns_lamp  (ns_lamp),
    .ew_lamp  (ew_lamp)
);

// File: tb/test_crossing_lights.sv
`timescale 1ns/1ps
module test_crossing_lights;
    localparam int D0 = 3;
    localparam int D1 = 2;
    localparam int D2 = 4;
    localparam int D3 = 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sec_tick = 1'b0;
    logic [2:0] ns_lamp;
    logic [2:0] ew_lamp;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int exp_ph = 0;
    int seen = 0;
    int red_ticks = 0;
    bit red_valid = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    crossing_lights #(
        .NS_GO_TICKS(D0), .NS_AMBER_TICKS(D1),
        .EW_GO_TICKS(D2), .EW_AMBER_TICKS(D3)
    ) i_crossing_lights (
        .clk(clk), .rst(rst), .sec_tick(sec_tick),
        .ns_lamp(ns_lamp), .ew_lamp(ew_lamp)
    );

    function automatic int dwell(input int p);
        case (p)
            0: return D0;
            1: return D1;
            2: return D2;
            default: return D3;
        endcase
    endfunction

    function automatic logic [2:0] exp_ns(input int p);
        return (p == 0) ? 3'b001 : (p == 1) ? 3'b010 : 3'b100;
    endfunction

    function automatic logic [2:0] exp_ew(input int p);
        return (p == 2) ? 3'b001 : (p == 3) ? 3'b010 : 3'b100;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
        end
    endtask

    // One clock: drive inputs, update model at the edge, check at the falling edge
    task automatic step(input bit t, input bit r);
        logic [2:0] prev_ns;
        prev_ns = ns_lamp;
        sec_tick = t;
        rst = r;
        @(posedge clk);
        if (r) begin
            exp_ph = 0; seen = 0; red_valid = 0; red_ticks = 0;
        end else if (t) begin
            if (prev_ns == 3'b100) red_ticks++;
            if (seen == dwell(exp_ph) - 1) begin
                exp_ph = (exp_ph + 1) % 4; seen = 0;
            end else begin
                seen++;
            end
        end
        @(negedge clk);
        check("R4/R5 ns lamp vs phase model", {29'd0, ns_lamp}, {29'd0, exp_ns(exp_ph)});
        check("R4/R5 ew lamp vs phase model", {29'd0, ew_lamp}, {29'd0, exp_ew(exp_ph)});
        check("R2 ns one-hot", $countones(ns_lamp), 1);
        check("R2 ew one-hot", $countones(ew_lamp), 1);
        check("R3 at least one red", {31'd0, ns_lamp[2] | ew_lamp[2]}, 1);
        if (!r) begin
            if (prev_ns != 3'b100 && ns_lamp == 3'b100) begin
                red_valid = 1; red_ticks = 0;
            end else if (prev_ns == 3'b100 && ns_lamp != 3'b100) begin
                if (red_valid) check("R7 ns red interval ticks", red_ticks, D2 + D3);
                red_valid = 0;
            end
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [5:0] held;
        int         hold_ticks;
        @(negedge clk);
        step(0, 1);
        step(0, 1);
        // R1: reset state
        check("R1 reset ns green", {29'd0, ns_lamp}, 32'h1);
        check("R1 reset ew red", {29'd0, ew_lamp}, 32'h4);

        // dense ticks
        for (int i = 0; i < 60; i++) step(1, 0);
        // every third cycle
        for (int i = 0; i < 90; i++) step(i % 3 == 0, 0);
        // pseudo-random pattern
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] & lfsr[3], 0);
        end

        // R6: long gap with no ticks, in every phase
        for (int k = 0; k < 4; k++) begin
            held = {ns_lamp, ew_lamp};
            for (int i = 0; i < 40; i++) step(0, 0);
            check("R6 outputs held without ticks", {26'd0, ns_lamp, ew_lamp}, {26'd0, held});
            for (int i = 0; i < 3; i++) step(1, 0);
        end

        // R1: reset in the middle of the EW green phase
        while (exp_ph != 2) step(1, 0);
        step(1, 0);
        step(0, 1);
        check("R1 mid-phase reset ns green", {29'd0, ns_lamp}, 32'h1);
        hold_ticks = 0;
        while (ns_lamp == 3'b001 && hold_ticks < 20) begin
            step(1, 0);
            hold_ticks++;
        end
        check("R1 first phase after reset full length", hold_ticks, D0);

        // R7 and R4 wrap under every-other-cycle ticks
        for (int i = 0; i < 120; i++) step(i % 2 == 1, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule